// File: doc/BRIEF.md
# Sync Symbol Phase Modulator

This block turns sync symbols into a stream of signed phase-offset words, one new word per millisecond, that a downstream carrier oscillator adds to its phase. Two symbol kinds exist. A trigger symbol spans 40 ms and carries one bit of a 64-bit synchronisation sequence. The bit is told apart by the frequency of a sinusoidal phase excursion of ±180 degrees. A '0' is two full cycles at 50 Hz, and a '1' is one and a half cycles at 37.5 Hz. A clock symbol spans 20 ms and holds a single 50 Hz cycle whose starting phase carries a dibit, so the 64 clock symbols of a sequence carry 128 bits.

Each symbol starts with a one-cycle strobe. The surrounding sequencer also supplies a 1 ms tick. The sinusoid is read from a quarter-wave table of 21 points. An accumulator indexes the table with 80 steps per full turn. A 50 Hz excursion advances it 4 steps per tick and a 37.5 Hz excursion advances it 3 steps per tick. A dibit moves the starting point by a whole quarter turn of 20 steps. The output is scaled by a depth parameter for each symbol kind.

Top module: `sync_phase_mod`

## Requirements
- R1: After reset, `busy` is 0 and `phase_out` is 0.
- R2: A trigger with `trig_bit`=0 produces 40 samples. Sample k (k=0..39) equals TRIG_AMP·sin(2π·4k/80) within 3 LSB.
- R3: A trigger with `trig_bit`=1 produces 40 samples. Sample k equals TRIG_AMP·sin(2π·3k/80) within 3 LSB.
- R4: A clock symbol produces 20 samples. Sample k equals CLK_AMP·sin(2π·(20d+4k)/80) within 3 LSB, where d is the unsigned value of `clk_dibit`. This maps 00→0°, 01→90°, 10→180° and 11→270°.
- R5: A start strobe seen while idle raises `busy` on the next clock edge and presents sample 0. Each later `tick_ms` advances the output by exactly one sample.
- R6: `busy` falls on the tick that follows the final sample. `phase_out` is 0 whenever `busy` is 0.
- R7: Start strobes that arrive while `busy` is 1 are ignored. This holds with or without a coincident tick, and the running symbol continues unchanged.
- R8: If `trig_start` and `clk_start` are both high in the same idle cycle, a trigger symbol is sent.
- R9: Between ticks, `phase_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| trig_start | input | 1 | Start strobe for a trigger symbol |
| trig_bit | input | 1 | Sync-sequence bit for the trigger symbol |
| clk_start | input | 1 | Start strobe for a clock symbol |
| clk_dibit | input | 2 | Dibit for the clock symbol |
| phase_out | output | PW | Signed phase offset, where 2^(PW-1) stands for 180° |
| busy | output | 1 | High while a symbol is being sent |

## Verification
Every sample of every symbol variant is compared with a sine computed in floating point: both trigger bits and all four dibits. The trigger pair shows whether the 3-step and 4-step advances are kept apart. The four dibits show whether the quarter-turn start offset and quadrant folding are correct. Further runs inject strobes mid-symbol, with and without a coincident tick, and assert both strobes together. These runs separate correct arbitration and start lockout from sequences that restart or switch kind. Idle gaps between ticks confirm that the output only moves on a tick.

// File: rtl/sync_phase_mod.sv
module sync_phase_mod #(
  parameter int PW       = 16,
  parameter int TRIG_AMP = (1 << (PW - 1)) - 1,
  parameter int CLK_AMP  = 1 << (PW - 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_ms,
  input  logic                 trig_start,
  input  logic                 trig_bit,
  input  logic                 clk_start,
  input  logic [1:0]           clk_dibit,
  output logic signed [PW-1:0] phase_out,
  output logic                 busy
);
  localparam int TURN     = 80;
  localparam int QTR      = TURN / 4;
  localparam int HALF     = TURN / 2;
  localparam int TRIG_LEN = 40;
  localparam int CLK_LEN  = 20;
  localparam int STEP_HI  = TURN / 20;
  localparam int STEP_LO  = 3 * TURN / 80;

  logic       trig_q;
  logic [6:0] step_q, acc_q;
  logic [5:0] cnt_q;
  logic [6:0] acc_nx, half_pos, idx;
  logic       neg;
  logic [15:0] lut_v;
  logic [PW-1:0] mag;

  function automatic logic [15:0] qsin(input logic [6:0] i);
    case (i)
      7'd0:  qsin = 16'd0;     7'd1:  qsin = 16'd2571;  7'd2:  qsin = 16'd5126;
      7'd3:  qsin = 16'd7649;  7'd4:  qsin = 16'd10126; 7'd5:  qsin = 16'd12539;
      7'd6:  qsin = 16'd14876; 7'd7:  qsin = 16'd17121; 7'd8:  qsin = 16'd19260;
      7'd9:  qsin = 16'd21280; 7'd10: qsin = 16'd23170; 7'd11: qsin = 16'd24916;
      7'd12: qsin = 16'd26509; 7'd13: qsin = 16'd27938; 7'd14: qsin = 16'd29196;
      7'd15: qsin = 16'd30273; 7'd16: qsin = 16'd31163; 7'd17: qsin = 16'd31862;
      7'd18: qsin = 16'd32364; 7'd19: qsin = 16'd32666; 7'd20: qsin = 16'd32767;
      default: qsin = 16'd0;
    endcase
  endfunction

  assign acc_nx = (acc_q + step_q >= 7'(TURN)) ? acc_q + step_q - 7'(TURN) : acc_q + step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      trig_q <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy) begin
      if (trig_start) begin
        busy   <= 1'b1;
        trig_q <= 1'b1;
        step_q <= trig_bit ? 7'(STEP_LO) : 7'(STEP_HI);
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (clk_start) begin
        busy   <= 1'b1;
        trig_q <= 1'b0;
        step_q <= 7'(STEP_HI);
        acc_q  <= 7'(QTR) * {5'd0, clk_dibit};
        cnt_q  <= '0;
      end
    end else if (tick_ms) begin
      if (cnt_q == (trig_q ? 6'(TRIG_LEN - 1) : 6'(CLK_LEN - 1))) begin
        busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 6'd1;
        acc_q <= acc_nx;
      end
    end
  end

  assign neg      = acc_q >= 7'(HALF);
  assign half_pos = neg ? acc_q - 7'(HALF) : acc_q;
  assign idx      = (half_pos > 7'(QTR)) ? 7'(HALF) - half_pos : half_pos;
  assign lut_v    = qsin(idx);
  assign mag      = PW'((48'(lut_v) * 48'(trig_q ? TRIG_AMP : CLK_AMP)) >> 15);
  assign phase_out = !busy ? '0 : (neg ? -$signed(mag) : $signed(mag));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick_ms |=> $stable(phase_out));
  // R5
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_start || clk_start));
  // R6
  fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick_ms));
  // R4
  clk_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !trig_q |-> (int'(phase_out) <= CLK_AMP && int'(phase_out) >= -CLK_AMP));
endmodule

// File: tb/sim_sync_phase_mod.sv
module sim_sync_phase_mod;
  logic clk = 0, rst_n = 0, tick_ms = 0, trig_start = 0, trig_bit = 0, clk_start = 0;
  logic [1:0] clk_dibit = 0;
  logic signed [15:0] phase_out;
  logic busy;
  int n_chk = 0, n_fail = 0;

  sync_phase_mod #(.PW(16), .TRIG_AMP(32767), .CLK_AMP(16384)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .trig_start(trig_start),
    .trig_bit(trig_bit), .clk_start(clk_start), .clk_dibit(clk_dibit),
    .phase_out(phase_out), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ideal(input int pos, input real amp);
    real v;
    v = amp * $sin(2.0 * 3.14159265358979 * pos / 80.0);
    return (v >= 0.0) ? int'(v + 0.5) : -int'(-v + 0.5);
  endfunction

  task automatic chk_sample(input string tag, input int pos, input real amp);
    int e;
    e = ideal(pos, amp);
    chk(busy && (int'(phase_out) - e <= 3) && (e - int'(phase_out) <= 3), tag, int'(phase_out), e);
  endtask

  task automatic run(input bit is_trig, input bit b, input logic [1:0] d,
                     input bit both, input bit disturb, input string tag);
    int len, step, base, hold;
    real amp;
    len  = is_trig ? 40 : 20;
    step = (is_trig && b) ? 3 : 4;
    base = is_trig ? 0 : 20 * int'(d);
    amp  = is_trig ? 32767.0 : 16384.0;
    @(negedge clk);
    trig_start = is_trig; trig_bit = b; clk_start = !is_trig || both; clk_dibit = d;
    @(negedge clk);
    trig_start = 0; clk_start = 0; trig_bit = !b; clk_dibit = ~d;
    chk(busy == 1'b1, "R5 busy after start", int'(busy), 1);
    chk_sample({tag, " k=0"}, base % 80, amp);
    hold = int'(phase_out);
    repeat (3) @(negedge clk);
    chk(int'(phase_out) == hold, "R9 hold between ticks", int'(phase_out), hold);
    for (int k = 1; k <= len; k++) begin
      if (disturb && k == 10) begin
        @(negedge clk); trig_start = 1; clk_start = 1; trig_bit = !b;
        @(negedge clk); trig_start = 0; clk_start = 0;
        chk_sample("R7 strobe while busy", (base + step * (k - 1)) % 80, amp);
      end
      @(negedge clk);
      tick_ms = 1;
      if (disturb && k == 20) clk_start = 1;
      @(negedge clk);
      tick_ms = 0; clk_start = 0;
      if (k < len) chk_sample({tag, (disturb ? " R7" : "")}, (base + step * k) % 80, amp);
    end
    chk(busy == 1'b0, "R6 busy falls after last sample", int'(busy), 0);
    chk(phase_out == 0, "R6 idle output zero", int'(phase_out), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(phase_out == 0, "R1 reset phase", int'(phase_out), 0);
    rst_n = 1;
    @(negedge clk);
    run(1, 0, 2'd0, 0, 0, "R2 trigger bit 0");
    run(1, 1, 2'd0, 0, 0, "R3 trigger bit 1");
    for (int d = 0; d < 4; d++) run(0, 0, 2'(d), 0, 0, "R4 clock dibit");
    run(1, 0, 2'd0, 0, 1, "R2 trigger disturbed");
    run(1, 1, 2'd2, 1, 0, "R8 both strobes R3");
    repeat (2) @(negedge clk);
    chk(phase_out == 0 && busy == 0, "R6 idle after runs", int'(phase_out), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule